// File: doc/BRIEF.md
# Compressed Jump, Branch and Load-Immediate Expander

This block turns a 16-bit compressed instruction into the full 32-bit base-integer instruction that does the same work. It handles seven compressed forms, all of them concerned with control flow or loading a small constant: the plain jump, the jump that links into x1, the register jump, the register jump that links, the two branch-on-zero forms, and the load of a small signed immediate. Each of these has exactly one wide equivalent. In that equivalent the destination, the second source or the base register is implied by the compressed form (x0 or x1). Alternatively a short 3-bit register field selects one of x8 to x15.

The logic is purely combinational. A decode stage sits between fetch and the main decoder and presents the halfword to `inst_i`. It takes the widened word from `exp_o` in the same cycle. Compressed jump and branch offsets count halfwords, because compressed code may sit on 2-byte boundaries. The expander therefore rebuilds each offset in bytes with bit 0 zero, and places it into the wide immediate layout. Any word outside the handled set is reported on `unhandled_o` so another expander can take it. The reserved encodings inside the set are reported on `illegal_o`.

Top module: `cfx_expander`

## Requirements
- R1: A word with inst[1:0]=01 and inst[15:13]=101 yields a jal with rd=x0. Its signed byte offset has bit 0 zero. Bits 11..1 come from inst bits 12, 8, 10, 9, 6, 7, 2, 11, 5, 4, 3 in that order, and bit 11 is sign-extended up to bit 20.
- R2: A word with inst[1:0]=01 and inst[15:13]=001 yields a jal with rd=x1, using the same offset as R1.
- R3: A word with inst[1:0]=01 and inst[15:13]=110 yields beq, and inst[15:13]=111 yields bne. In both, rs1 = 8 + inst[9:7] and rs2 = x0. The offset has bit 0 zero, and bits 8..1 come from inst bits 12, 6, 5, 2, 11, 10, 4, 3 in that order. Bit 8 is sign-extended up to bit 12.
- R4: A word with inst[1:0]=10, inst[15:12]=1000, inst[6:2]=0 and inst[11:7]≠0 yields jalr with rd=x0, rs1=inst[11:7] and immediate 0.
- R5: A word with inst[1:0]=10, inst[15:12]=1001, inst[6:2]=0 and inst[11:7]≠0 yields jalr with rd=x1, rs1=inst[11:7] and immediate 0.
- R6: A word with inst[1:0]=01 and inst[15:13]=010 yields addi with rd=inst[11:7] and rs1=x0. Its 12-bit immediate is the sign-extended 6-bit value {inst[12], inst[6:2]}. This holds for every rd, x0 included.
- R7: The all-zero word, and the R4 pattern with inst[11:7]=0, raise `illegal_o`. When `illegal_o` is raised, `exp_o` is all zeros and `unhandled_o` is low.
- R8: Every other word raises `unhandled_o` with `exp_o` all zeros and `illegal_o` low. This covers inst[1:0]=11, inst[1:0]=00 when nonzero, the other quadrant-01 funct3 values, and the quadrant-10 words with inst[6:2]≠0 or with inst[15:12]=1001 and inst[11:7]=0.
- R9: `illegal_o` and `unhandled_o` are never high together, and a handled word always gives an `exp_o` with bits [1:0]=11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| inst_i | input | 16 | Compressed instruction halfword |
| exp_o | output | 32 | Equivalent 32-bit instruction, zero when not produced |
| illegal_o | output | 1 | Reserved encoding inside the handled set |
| unhandled_o | output | 1 | Word belongs to another expander or is not compressed |

## Verification
Every result is due in the same cycle as its input, because no register lies between `inst_i` and the three outputs. The driver changes `inst_i` just after a rising edge and queues the expected word and flags. The monitor takes them off the queue at the following falling edge, half a period later, so each comparison sees settled logic and never a value from the neighbouring stimulus. The jump and branch offsets are swept over their whole even range, the limits included. Hand-assembled words anchor the most negative offsets and the return idiom.

// File: rtl/cfx_pkg.sv
// Package for the compressed control-flow expander.
// Holds the word widths, the wide major opcodes, the fixed registers the
// compressed forms imply, and the classification type shared by the stages.
package cfx_pkg;

    localparam int CW = 16;   // compressed word width
    localparam int IW = 32;   // expanded word width
    localparam int RW = 5;    // register index width

    localparam int JOFS_W = 21;  // jal byte offset width
    localparam int BOFS_W = 13;  // branch byte offset width
    localparam int LIMM_W = 12;  // addi immediate width

    localparam logic [6:0] OPC_JAL    = 7'b1101111;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_OPIMM  = 7'b0010011;

    localparam logic [2:0] F3_BEQ  = 3'b000;
    localparam logic [2:0] F3_BNE  = 3'b001;
    localparam logic [2:0] F3_ZERO = 3'b000;

    localparam logic [RW-1:0] REG_ZERO = 5'd0;
    localparam logic [RW-1:0] REG_LINK = 5'd1;

    // What a compressed word turned out to be
    typedef enum logic [3:0] {
        K_NONE,   // outside the handled set
        K_ILL,    // reserved inside the handled set
        K_J,
        K_JAL,
        K_BEQZ,
        K_BNEZ,
        K_JR,
        K_JALR,
        K_LI
    } cfx_kind_e;

    // Fields recovered from a compressed word
    typedef struct packed {
        logic [JOFS_W-1:0] jofs;
        logic [BOFS_W-1:0] bofs;
        logic [LIMM_W-1:0] limm;
        logic [RW-1:0]     rfull;
        logic [RW-1:0]     rprime;
    } cfx_fields_t;

endpackage

// File: rtl/cfx_classify.sv
// Classifier: sorts a compressed halfword into one of the handled forms,
// a reserved form, or "not ours". Assumes nothing about alignment; it
// sees only the 16 bits it is given.
module cfx_classify
    import cfx_pkg::*;
(
    input  logic [CW-1:0] inst_i,
    output cfx_kind_e     kind_o
);

    localparam logic [1:0] Q_ONE = 2'b01;
    localparam logic [1:0] Q_TWO = 2'b10;

    logic [2:0]    f3;
    logic [RW-1:0] r_hi;
    logic [RW-1:0] r_lo;

    assign f3   = inst_i[15:13];
    assign r_hi = inst_i[11:7];
    assign r_lo = inst_i[6:2];

    // Pick the form from quadrant, funct3 and the register fields
    always_comb begin
        kind_o = K_NONE;
        if (inst_i == '0) begin
            kind_o = K_ILL;
        end else begin
            case (inst_i[1:0])
                Q_ONE: begin
                    case (f3)
                        3'b101:  kind_o = K_J;
                        3'b001:  kind_o = K_JAL;
                        3'b110:  kind_o = K_BEQZ;
                        3'b111:  kind_o = K_BNEZ;
                        3'b010:  kind_o = K_LI;
                        default: kind_o = K_NONE;
                    endcase
                end
                Q_TWO: begin
                    if (f3 == 3'b100 && r_lo == '0) begin
                        if (!inst_i[12]) begin
                            kind_o = (r_hi == '0) ? K_ILL : K_JR;
                        end else if (r_hi != '0) begin
                            kind_o = K_JALR;
                        end
                    end
                end
                default: kind_o = K_NONE;
            endcase
        end
    end

endmodule

// File: rtl/cfx_unpack.sv
// Field recovery: unscrambles the compressed offsets into byte offsets
// (bit 0 zero, sign-extended), widens the small immediate and maps the
// short register field onto the upper register bank. Computes every field
// unconditionally; the classifier decides which one is used.
module cfx_unpack
    import cfx_pkg::*;
#(
    parameter int REG_BASE = 8
) (
    input  logic [CW-1:0] inst_i,
    output cfx_fields_t   fld_o
);

    localparam int JSIG = 12;   // significant bits of jump offset incl. bit 0
    localparam int BSIG = 9;    // significant bits of branch offset incl. bit 0
    localparam int LSIG = 6;    // significant bits of load immediate

    logic [JSIG-1:0] j_raw;
    logic [BSIG-1:0] b_raw;
    logic [LSIG-1:0] l_raw;

    // Gather the scattered offset and immediate bits in order
    always_comb begin
        j_raw = {inst_i[12], inst_i[8], inst_i[10:9], inst_i[6], inst_i[7],
                 inst_i[2], inst_i[11], inst_i[5:3], 1'b0};
        b_raw = {inst_i[12], inst_i[6:5], inst_i[2], inst_i[11:10],
                 inst_i[4:3], 1'b0};
        l_raw = {inst_i[12], inst_i[6:2]};
    end

    // Sign-extend each value to the width the wide format carries
    always_comb begin
        fld_o.jofs   = {{(JOFS_W-JSIG){j_raw[JSIG-1]}}, j_raw};
        fld_o.bofs   = {{(BOFS_W-BSIG){b_raw[BSIG-1]}}, b_raw};
        fld_o.limm   = {{(LIMM_W-LSIG){l_raw[LSIG-1]}}, l_raw};
        fld_o.rfull  = inst_i[11:7];
        fld_o.rprime = RW'(REG_BASE) + {2'b00, inst_i[9:7]};
    end

endmodule

// File: rtl/cfx_pack.sv
// Assembler: lays the recovered fields into the 32-bit layout that matches
// the classified form. Anything not handled produces an all-zero word.
module cfx_pack
    import cfx_pkg::*;
(
    input  cfx_kind_e   kind_i,
    input  cfx_fields_t fld_i,
    output logic [IW-1:0] word_o
);

    logic [RW-1:0] link_rd;
    logic [2:0]    br_f3;

    // Implied destination and branch condition for the paired forms
    always_comb begin
        link_rd = (kind_i == K_JAL || kind_i == K_JALR) ? REG_LINK : REG_ZERO;
        br_f3   = (kind_i == K_BNEZ) ? F3_BNE : F3_BEQ;
    end

    // Build the wide word in the format of its class
    always_comb begin
        case (kind_i)
            K_J, K_JAL: begin
                word_o = {fld_i.jofs[20], fld_i.jofs[10:1], fld_i.jofs[11],
                          fld_i.jofs[19:12], link_rd, OPC_JAL};
            end
            K_BEQZ, K_BNEZ: begin
                word_o = {fld_i.bofs[12], fld_i.bofs[10:5], REG_ZERO,
                          fld_i.rprime, br_f3, fld_i.bofs[4:1],
                          fld_i.bofs[11], OPC_BRANCH};
            end
            K_JR, K_JALR: begin
                word_o = {12'd0, fld_i.rfull, F3_ZERO, link_rd, OPC_JALR};
            end
            K_LI: begin
                word_o = {fld_i.limm, REG_ZERO, F3_ZERO, fld_i.rfull, OPC_OPIMM};
            end
            default: word_o = '0;
        endcase
    end

endmodule

// File: rtl/cfx_expander.sv
// Top of the compressed control-flow expander. Combinational: the output
// word and flags follow inst_i with no state. Assumes the caller has already
// separated 16-bit words from 32-bit ones where it needs to; quadrant 11 is
// simply reported as not handled.
module cfx_expander
    import cfx_pkg::*;
#(
    parameter int REG_BASE = 8
) (
    input  logic [15:0] inst_i,
    output logic [31:0] exp_o,
    output logic        illegal_o,
    output logic        unhandled_o
);

    cfx_kind_e   kind;
    cfx_fields_t fld;

    cfx_classify u_classify (
        .inst_i (inst_i),
        .kind_o (kind)
    );

    cfx_unpack #(
        .REG_BASE (REG_BASE)
    ) u_unpack (
        .inst_i (inst_i),
        .fld_o  (fld)
    );

    cfx_pack u_pack (
        .kind_i (kind),
        .fld_i  (fld),
        .word_o (exp_o)
    );

    // Flags come straight from the classification
    always_comb begin
        illegal_o   = (kind == K_ILL);
        unhandled_o = (kind == K_NONE);
    end

endmodule

// File: rtl/cfx_expander_chk.sv
// Checker for cfx_expander: relates the ports of the combinational expander.
// Uses immediate assertions because the block has no clock.
module cfx_expander_chk
    import cfx_pkg::*;
(
    input logic [15:0] inst_i,
    input logic [31:0] exp_o,
    input logic        illegal_o,
    input logic        unhandled_o
);

    // Flag and word consistency on every input change
    always_comb begin
        a_r9_flags_exclusive: assert (!(illegal_o && unhandled_o));
        if (illegal_o) begin
            a_r7_illegal_zero: assert (exp_o == '0 && !unhandled_o);
        end
        if (unhandled_o) begin
            a_r8_unhandled_zero: assert (exp_o == '0 && !illegal_o);
        end
        if (inst_i == '0) begin
            a_r7_zero_word: assert (illegal_o);
        end
        if (inst_i[1:0] == 2'b11) begin
            a_r8_wide_word: assert (unhandled_o);
        end
        if (!illegal_o && !unhandled_o) begin
            a_r9_wide_low_bits: assert (exp_o[1:0] == 2'b11);
        end
    end

    // Shape of each produced wide format
    always_comb begin
        if (exp_o[6:0] == OPC_JAL) begin
            a_r1_jal_rd: assert (exp_o[11:8] == 4'd0);
        end
        if (exp_o[6:0] == OPC_BRANCH) begin
            a_r3_branch_regs: assert (exp_o[24:20] == 5'd0 && exp_o[19:18] == 2'b01
                                      && exp_o[14:13] == 2'b00);
        end
        if (exp_o[6:0] == OPC_JALR) begin
            a_r4_jalr_form: assert (exp_o[31:20] == 12'd0 && exp_o[19:15] == inst_i[11:7]
                                    && exp_o[19:15] != 5'd0 && exp_o[11:8] == 4'd0);
        end
        if (exp_o[6:0] == OPC_OPIMM) begin
            a_r6_li_form: assert (exp_o[19:12] == 8'd0 && exp_o[11:7] == inst_i[11:7]);
        end
    end

endmodule

bind cfx_expander cfx_expander_chk u_chk (
    .inst_i      (inst_i),
    .exp_o       (exp_o),
    .illegal_o   (illegal_o),
    .unhandled_o (unhandled_o)
);

// File: tb/tb_cfx_expander.sv
// Scoreboard bench for cfx_expander: the driver queues the expected result
// for each halfword it applies; the monitor compares at the falling edge.
module tb_cfx_expander;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 100000;

    typedef struct {
        logic [15:0] inst;
        logic [31:0] word;
        logic        ill;
        logic        unh;
        string       req;
    } item_t;

    logic        clk;
    logic        rst_n;
    logic [15:0] inst_i;
    logic [31:0] exp_o;
    logic        illegal_o;
    logic        unhandled_o;

    int tests;
    int fails;
    bit done;
    item_t sb_q[$];

    cfx_expander dut (
        .inst_i      (inst_i),
        .exp_o       (exp_o),
        .illegal_o   (illegal_o),
        .unhandled_o (unhandled_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // ---- bench-side encoders, written from the requirements ----
    function automatic logic [15:0] c_jump(bit link, int off);
        logic [31:0] o;
        o = off;
        return {(link ? 3'b001 : 3'b101), o[11], o[4], o[9:8], o[10], o[6],
                o[7], o[3:1], o[5], 2'b01};
    endfunction

    function automatic logic [31:0] w_jal(bit link, int off);
        logic [31:0] o;
        o = off;
        return {o[20], o[10:1], o[11], o[19:12], (link ? 5'd1 : 5'd0), 7'b1101111};
    endfunction

    function automatic logic [15:0] c_branch(bit ne, int rp, int off);
        logic [31:0] o;
        logic [31:0] r;
        o = off;
        r = rp;
        return {(ne ? 3'b111 : 3'b110), o[8], o[4:3], r[2:0], o[7:6], o[2:1],
                o[5], 2'b01};
    endfunction

    function automatic logic [31:0] w_branch(bit ne, int rp, int off);
        logic [31:0] o;
        logic [31:0] r;
        o = off;
        r = rp + 8;
        return {o[12], o[10:5], 5'd0, r[4:0], (ne ? 3'b001 : 3'b000), o[4:1],
                o[11], 7'b1100011};
    endfunction

    function automatic logic [15:0] c_li(int rd, int imm);
        logic [31:0] i;
        logic [31:0] r;
        i = imm;
        r = rd;
        return {3'b010, i[5], r[4:0], i[4:0], 2'b01};
    endfunction

    function automatic logic [31:0] w_addi(int rd, int imm);
        logic [31:0] i;
        logic [31:0] r;
        i = imm;
        r = rd;
        return {i[11:0], 5'd0, 3'b000, r[4:0], 7'b0010011};
    endfunction

    function automatic logic [31:0] w_jalr(bit link, int rs);
        logic [31:0] r;
        r = rs;
        return {12'd0, r[4:0], 3'b000, (link ? 5'd1 : 5'd0), 7'b1100111};
    endfunction

    // ---- driver: apply one halfword, queue its expected result ----
    task automatic drive(input logic [15:0] ins, input logic [31:0] w,
                         input logic ill, input logic unh, input string req);
        item_t it;
        @(posedge clk);
        inst_i = ins;
        it.inst = ins;
        it.word = w;
        it.ill  = ill;
        it.unh  = unh;
        it.req  = req;
        sb_q.push_back(it);
    endtask

    // ---- monitor: one comparison per falling edge ----
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                tests++;
                if (exp_o !== it.word || illegal_o !== it.ill || unhandled_o !== it.unh) begin
                    fails++;
                    $display("FAIL %s inst=%h got word=%h ill=%b unh=%b expected word=%h ill=%b unh=%b",
                             it.req, it.inst, exp_o, illegal_o, unhandled_o,
                             it.word, it.ill, it.unh);
                end
            end
        end
    end

    // ---- watchdog ----
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired after %0d cycles, expected completion", WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // ---- stimulus ----
    initial begin
        tests  = 0;
        fails  = 0;
        done   = 1'b0;
        inst_i = 16'h0000;
        rst_n  = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Start-up state: all-zero word is illegal (R7)
        drive(16'h0000, 32'h0, 1'b1, 1'b0, "R7 zero word");

        // Hand-assembled anchors
        drive(16'h8082, 32'h00008067, 1'b0, 1'b0, "R4 return via x1");
        drive(16'h9282, 32'h000280E7, 1'b0, 1'b0, "R5 call via x5");
        drive(16'h557D, 32'hFFF00513, 1'b0, 1'b0, "R6 load -1 into x10");
        drive(16'hB001, 32'h801FF06F, 1'b0, 1'b0, "R1 jump -2048");
        drive(16'hD001, 32'hF00400E3, 1'b0, 1'b0, "R3 beqz x8 -256");
        drive(16'h8002, 32'h0, 1'b1, 1'b0, "R7 register jump via x0");

        // Words outside the handled set (R8)
        drive(16'h0001, 32'h0, 1'b0, 1'b1, "R8 quadrant-01 funct3 000");
        drive(16'h0003, 32'h0, 1'b0, 1'b1, "R8 quadrant 11");
        drive(16'h808A, 32'h0, 1'b0, 1'b1, "R8 register move form");
        drive(16'h9002, 32'h0, 1'b0, 1'b1, "R8 breakpoint form");
        drive(16'h908A, 32'h0, 1'b0, 1'b1, "R8 register add form");
        drive(16'h4000, 32'h0, 1'b0, 1'b1, "R8 quadrant 00 nonzero");
        drive(16'h6001, 32'h0, 1'b0, 1'b1, "R8 quadrant-01 funct3 011");

        // Full even offset range for both jump forms (R1, R2)
        for (int off = -2048; off <= 2046; off += 2) begin
            drive(c_jump(1'b0, off), w_jal(1'b0, off), 1'b0, 1'b0, "R1 jump sweep");
            drive(c_jump(1'b1, off), w_jal(1'b1, off), 1'b0, 1'b0, "R2 linked jump sweep");
        end

        // Both branch forms, every short register, full range (R3)
        for (int rp = 0; rp < 8; rp++) begin
            for (int off = -256; off <= 254; off += 2) begin
                drive(c_branch(1'b0, rp, off), w_branch(1'b0, rp, off), 1'b0, 1'b0, "R3 beqz sweep");
                drive(c_branch(1'b1, rp, off), w_branch(1'b1, rp, off), 1'b0, 1'b0, "R3 bnez sweep");
            end
        end

        // Register jumps over every nonzero base (R4, R5)
        for (int rs = 1; rs < 32; rs++) begin
            drive(16'h8002 | 16'(rs << 7), w_jalr(1'b0, rs), 1'b0, 1'b0, "R4 register jump sweep");
            drive(16'h9002 | 16'(rs << 7), w_jalr(1'b1, rs), 1'b0, 1'b0, "R5 linked register jump sweep");
        end

        // Load immediate for every destination and value (R6)
        for (int rd = 0; rd < 32; rd++) begin
            for (int imm = -32; imm <= 31; imm++) begin
                drive(c_li(rd, imm), w_addi(rd, imm), 1'b0, 1'b0, "R6 load immediate sweep");
            end
        end

        // Flags never both high and handled words end in 11 (R9)
        drive(16'hFFFF, 32'h0, 1'b0, 1'b1, "R9 all-ones word");
        drive(c_jump(1'b0, 2046), w_jal(1'b0, 2046), 1'b0, 1'b0, "R9 max positive jump");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule